// File: doc/BRIEF.md
# Time-of-Day and Calendar Counter with Daylight-Saving Steps

This block holds seconds, minutes and hours together with a day of the week, a date and a month, and advances them by one second each time a one-cycle tick strobe arrives. Every stored byte is kept in the format software chose: packed decimal (two 4-bit digits) or plain binary. The hours byte is either a 0–23 count or a 1–12 count with bit 7 as the afternoon flag. Both choices are made through a control byte on the same simple write port that loads the time and calendar bytes.

A freeze bit in the control byte stops all advancing. Software can then load the fields without a carry landing halfway through. Setting the freeze bit also clears the update-ended interrupt enable. Each advance produces a one-cycle update-ended pulse, which sets a sticky flag. When the enable is on, that flag drives an interrupt output. With daylight saving switched on, the clock skips the hour after 1:59:59 on the first Sunday of April, and repeats that hour once on the last Sunday of October.

Top module: `rtc_tod`

## Requirements
- R1: After synchronous reset, seconds, minutes and hours read 8'h00, day of week, date and month read 8'h01, ctrl_o reads 8'h02 (24-hour, packed decimal, no daylight saving, not frozen, interrupt disabled), and upd_pulse, upd_flag and upd_irq are 0.
- R2: A tick with no write in the same cycle and freeze clear advances the time one second. The carries run seconds to minutes to hours, and 23:59:59 wraps to 00:00:00. upd_pulse is 1 for the one cycle after that edge, and upd_flag is 1 from the edge after that. upd_flag clears on flag_ack, unless a new pulse sets it in the same cycle. upd_irq equals upd_flag AND the interrupt enable.
- R3: While the freeze bit (ctrl bit 4) is 1, ticks change no time or calendar byte and give no pulse. Writes still load the fields.
- R4: Any control write with bit 4 set leaves the interrupt enable (ctrl bit 3) at 0, whatever bit 3 of the written byte is.
- R5: Control bit 2 = 1 selects binary storage. Bit 2 = 0 selects packed decimal, where the high nibble is the tens digit and the low nibble is the units digit. Advances follow the selected format.
- R6: Control bit 1 = 1 selects 24-hour hours (0–23). Bit 1 = 0 selects a 1–12 count in bits 6:0, with bit 7 set for PM. 11:59:59 AM goes to 12:00:00 PM, 12:59:59 PM goes to 1:00:00 PM, and 11:59:59 PM goes to 12:00:00 AM together with a day advance.
- R7: Each day advance steps the day of week 1..7 (7 wraps to 1) and steps the date. From the last day of the month the date goes to 1 and the month steps, with 12 wrapping to 1. February has 28 days; April, June, September and November have 30; the rest have 31.
- R8: With daylight saving on (ctrl bit 0), on a Sunday (day of week 1) in April with date 1–7, a tick at 1:59:59 AM gives 3:00:00 AM.
- R9: With daylight saving on, on a Sunday in October with date 25 or later, the first tick at 1:59:59 AM gives 1:00:00 AM and arms a one-shot guard. While the guard is armed, 1:59:59 advances normally. The guard clears on a day advance or on a write to the date byte.
- R10: With daylight saving off, 1:59:59 AM always advances to 2:00:00 AM.
- R11: Any write in the same cycle as a tick takes the write and drops the tick: no advance and no pulse.
- R12: A control write changes no stored time or calendar byte. Stored bytes are not converted when the format changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle one-second strobe |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | 0 sec, 1 min, 2 hour, 3 day of week, 4 date, 5 month, 6 control, 7 none |
| wr_data | input | 8 | Write data |
| flag_ack | input | 1 | Clears the update-ended flag |
| sec_o | output | 8 | Seconds byte |
| min_o | output | 8 | Minutes byte |
| hour_o | output | 8 | Hours byte |
| dow_o | output | 8 | Day-of-week byte |
| date_o | output | 8 | Date byte |
| month_o | output | 8 | Month byte |
| ctrl_o | output | 8 | Control byte: bit0 daylight saving, bit1 24-hour, bit2 binary, bit3 interrupt enable, bit4 freeze |
| upd_pulse | output | 1 | One-cycle update-ended pulse |
| upd_flag | output | 1 | Sticky update-ended flag |
| upd_irq | output | 1 | Flag gated by interrupt enable |

## Verification
A wrong carry or a wrong format conversion shows in a time byte in the cycle right after the tick edge. A stale one-shot daylight-saving guard stays hidden until the next 1:59:59 on an October Sunday. There it shows as a missing or repeated fall-back, so the bench loads that time again straight after a day advance or a date write. A bad freeze or interrupt-enable bit shows on ctrl_o, upd_pulse and upd_irq within one cycle. The bench's reference model compares every output on every clock, so each of these faults is caught in the first cycle it reaches a port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int FIELD_W = 8;
    localparam int NUM_W   = 7;

    typedef struct packed {
        logic [FIELD_W-1:0] sec;
        logic [FIELD_W-1:0] min;
        logic [FIELD_W-1:0] hour;
    } tod_t;

    typedef struct packed {
        logic [FIELD_W-1:0] dow;
        logic [FIELD_W-1:0] date;
        logic [FIELD_W-1:0] month;
    } cal_t;

    // bit order equals the control byte layout: set=4 .. dst=0
    typedef struct packed {
        logic set;
        logic uie;
        logic bin;
        logic h24;
        logic dst;
    } ctrl_t;

    typedef enum logic [2:0] {
        A_SEC   = 3'd0,
        A_MIN   = 3'd1,
        A_HOUR  = 3'd2,
        A_DOW   = 3'd3,
        A_DATE  = 3'd4,
        A_MONTH = 3'd5,
        A_CTRL  = 3'd6,
        A_NONE  = 3'd7
    } addr_e;

    function automatic logic [NUM_W-1:0] to_num(input logic [FIELD_W-1:0] v, input logic bin);
        logic [NUM_W-1:0] tens;
        tens = NUM_W'(v[7:4]) * NUM_W'(10);
        return bin ? v[NUM_W-1:0] : tens + NUM_W'(v[3:0]);
    endfunction

    function automatic logic [FIELD_W-1:0] from_num(input logic [NUM_W-1:0] n, input logic bin);
        logic [NUM_W-1:0] t;
        logic [NUM_W-1:0] u;
        t = n / NUM_W'(10);
        u = n - t * NUM_W'(10);
        return bin ? {1'b0, n} : {t[3:0], u[3:0]};
    endfunction

    function automatic logic [NUM_W-1:0] month_len(input logic [NUM_W-1:0] m);
        case (m)
            NUM_W'(2):                                   return NUM_W'(28);
            NUM_W'(4), NUM_W'(6), NUM_W'(9), NUM_W'(11): return NUM_W'(30);
            default:                                     return NUM_W'(31);
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_next.sv
module rtc_time_next
    import rtc_pkg::*;
#(
    parameter int SUNDAY_CODE      = 1,
    parameter int SPRING_MONTH     = 4,
    parameter int SPRING_LAST_DATE = 7,
    parameter int FALL_MONTH       = 10,
    parameter int FALL_FIRST_DATE  = 25
) (
    input  tod_t cur,
    input  cal_t cal,
    input  logic bin,
    input  logic h24,
    input  logic dst,
    input  logic fell_q,
    output tod_t nxt,
    output logic day_carry,
    output logic fall_now
);
    localparam logic [NUM_W-1:0] LAST_MS   = NUM_W'(59);
    localparam logic [NUM_W-1:0] LAST_HR   = NUM_W'(23);
    localparam logic [NUM_W-1:0] NOON      = NUM_W'(12);
    localparam logic [NUM_W-1:0] SPRING_TO = NUM_W'(3);
    localparam logic [NUM_W-1:0] FALL_TO   = NUM_W'(1);

    logic [NUM_W-1:0] s, m, hraw, h, mon, dt, dw;
    logic [NUM_W-1:0] ns, nm, nh, h12;
    logic             pm, at_edge, sunday, spring;
    logic [FIELD_W-1:0] henc;

    always_comb begin
        s    = to_num(cur.sec, bin);
        m    = to_num(cur.min, bin);
        pm   = ~h24 & cur.hour[7];
        hraw = to_num(h24 ? cur.hour : {1'b0, cur.hour[6:0]}, bin);
        if (h24)              h = hraw;
        else if (hraw == NOON) h = pm ? NOON : '0;
        else                  h = pm ? hraw + NOON : hraw;

        mon = to_num(cal.month, bin);
        dt  = to_num(cal.date, bin);
        dw  = to_num(cal.dow, bin);

        at_edge  = (h == NUM_W'(1)) && (m == LAST_MS) && (s == LAST_MS);
        sunday   = (dw == NUM_W'(SUNDAY_CODE));
        spring   = dst && at_edge && sunday && (mon == NUM_W'(SPRING_MONTH))
                   && (dt <= NUM_W'(SPRING_LAST_DATE));
        fall_now = dst && at_edge && sunday && (mon == NUM_W'(FALL_MONTH))
                   && (dt >= NUM_W'(FALL_FIRST_DATE)) && !fell_q && !spring;

        ns = (s == LAST_MS) ? '0 : s + 1'b1;
        nm = (s == LAST_MS) ? ((m == LAST_MS) ? '0 : m + 1'b1) : m;
        nh = h;
        day_carry = 1'b0;
        if (s == LAST_MS && m == LAST_MS) begin
            nh        = (h == LAST_HR) ? '0 : h + 1'b1;
            day_carry = (h == LAST_HR);
        end
        if (spring) begin
            nh = SPRING_TO; nm = '0; ns = '0;
        end else if (fall_now) begin
            nh = FALL_TO;   nm = '0; ns = '0;
        end

        if (nh == '0)        h12 = NOON;
        else if (nh > NOON)  h12 = nh - NOON;
        else                 h12 = nh;
        henc = from_num(h12, bin);

        nxt.sec  = from_num(ns, bin);
        nxt.min  = from_num(nm, bin);
        nxt.hour = h24 ? from_num(nh, bin) : {(nh >= NOON), henc[6:0]};
    end

endmodule

// File: rtl/rtc_cal_next.sv
module rtc_cal_next
    import rtc_pkg::*;
#(
    parameter int DAYS_PER_WEEK = 7,
    parameter int MONTHS        = 12
) (
    input  cal_t cur,
    input  logic bin,
    output cal_t nxt
);
    logic [NUM_W-1:0] dw, dt, mo, ndw, ndt, nmo;

    always_comb begin
        dw  = to_num(cur.dow, bin);
        dt  = to_num(cur.date, bin);
        mo  = to_num(cur.month, bin);
        ndw = (dw >= NUM_W'(DAYS_PER_WEEK)) ? NUM_W'(1) : dw + 1'b1;
        if (dt >= month_len(mo)) begin
            ndt = NUM_W'(1);
            nmo = (mo >= NUM_W'(MONTHS)) ? NUM_W'(1) : mo + 1'b1;
        end else begin
            ndt = dt + 1'b1;
            nmo = mo;
        end
        nxt.dow   = from_num(ndw, bin);
        nxt.date  = from_num(ndt, bin);
        nxt.month = from_num(nmo, bin);
    end

endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
    import rtc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_ctrl,
    input  logic [4:0]  wr_bits,
    input  logic        upd_pulse,
    input  logic        flag_ack,
    output ctrl_t       ctrl_q,
    output logic        upd_flag,
    output logic        upd_irq
);
    ctrl_t wr_c;
    assign wr_c = ctrl_t'(wr_bits);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '{set: 1'b0, uie: 1'b0, bin: 1'b0, h24: 1'b1, dst: 1'b0};
            upd_flag <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q     <= wr_c;
                ctrl_q.uie <= wr_c.uie & ~wr_c.set;
            end
            if (upd_pulse)     upd_flag <= 1'b1;
            else if (flag_ack) upd_flag <= 1'b0;
        end
    end

    assign upd_irq = upd_flag & ctrl_q.uie;

    // R4: freeze written high leaves the interrupt enable low
    p_uie_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && wr_bits[4]) |=> !ctrl_q.uie);

    // R2: every update-ended pulse raises the sticky flag
    p_flag_set_r2: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |=> upd_flag);

endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
    import rtc_pkg::*;
#(
    parameter int SUNDAY_CODE      = 1,
    parameter int SPRING_MONTH     = 4,
    parameter int SPRING_LAST_DATE = 7,
    parameter int FALL_MONTH       = 10,
    parameter int FALL_FIRST_DATE  = 25,
    parameter int DAYS_PER_WEEK    = 7,
    parameter int MONTHS           = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [7:0]   wr_data,
    input  logic         flag_ack,
    output logic [7:0]   sec_o,
    output logic [7:0]   min_o,
    output logic [7:0]   hour_o,
    output logic [7:0]   dow_o,
    output logic [7:0]   date_o,
    output logic [7:0]   month_o,
    output logic [7:0]   ctrl_o,
    output logic         upd_pulse,
    output logic         upd_flag,
    output logic         upd_irq
);
    localparam int CTRL_W = $bits(ctrl_t);
    localparam int PAD_W  = FIELD_W - CTRL_W;

    tod_t  tod_q, tod_n;
    cal_t  cal_q, cal_n;
    ctrl_t ctrl_q;
    logic  fell_q, day_carry, fall_now, upd_q;
    addr_e addr;

    assign addr = addr_e'(wr_addr);

    rtc_time_next #(
        .SUNDAY_CODE(SUNDAY_CODE), .SPRING_MONTH(SPRING_MONTH),
        .SPRING_LAST_DATE(SPRING_LAST_DATE), .FALL_MONTH(FALL_MONTH),
        .FALL_FIRST_DATE(FALL_FIRST_DATE)
    ) i_time (
        .cur(tod_q), .cal(cal_q), .bin(ctrl_q.bin), .h24(ctrl_q.h24),
        .dst(ctrl_q.dst), .fell_q(fell_q), .nxt(tod_n),
        .day_carry(day_carry), .fall_now(fall_now)
    );

    rtc_cal_next #(.DAYS_PER_WEEK(DAYS_PER_WEEK), .MONTHS(MONTHS)) i_cal (
        .cur(cal_q), .bin(ctrl_q.bin), .nxt(cal_n)
    );

    rtc_ctrl i_ctrl (
        .clk(clk), .rst(rst), .wr_ctrl(wr_en && addr == A_CTRL),
        .wr_bits(wr_data[CTRL_W-1:0]), .upd_pulse(upd_q), .flag_ack(flag_ack),
        .ctrl_q(ctrl_q), .upd_flag(upd_flag), .upd_irq(upd_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tod_q  <= '0;
            cal_q  <= '{dow: 8'h01, date: 8'h01, month: 8'h01};
            fell_q <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (wr_en) begin
                case (addr)
                    A_SEC:   tod_q.sec   <= wr_data;
                    A_MIN:   tod_q.min   <= wr_data;
                    A_HOUR:  tod_q.hour  <= wr_data;
                    A_DOW:   cal_q.dow   <= wr_data;
                    A_DATE:  begin cal_q.date <= wr_data; fell_q <= 1'b0; end
                    A_MONTH: cal_q.month <= wr_data;
                    default: ;
                endcase
            end else if (tick && !ctrl_q.set) begin
                tod_q <= tod_n;
                upd_q <= 1'b1;
                if (day_carry) begin
                    cal_q  <= cal_n;
                    fell_q <= 1'b0;
                end
                if (fall_now) fell_q <= 1'b1;
            end
        end
    end

    assign sec_o     = tod_q.sec;
    assign min_o     = tod_q.min;
    assign hour_o    = tod_q.hour;
    assign dow_o     = cal_q.dow;
    assign date_o    = cal_q.date;
    assign month_o   = cal_q.month;
    assign ctrl_o    = {{PAD_W{1'b0}}, ctrl_q};
    assign upd_pulse = upd_q;

    // R3: frozen and not written, time and calendar hold
    p_freeze_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.set && !wr_en) |=> ($stable(tod_q) && $stable(cal_q)));

    // R3: no update-ended pulse follows a frozen cycle
    p_freeze_no_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.set |=> !upd_pulse);

    // R11: a write cycle never produces an update
    p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !upd_pulse);

    // R2: a pulse is always preceded by a tick
    p_pulse_needs_tick_r2: assert property (@(posedge clk) disable iff (rst)
        upd_pulse |-> $past(tick));

endmodule

// File: tb/test_rtc_tod.sv
module test_rtc_tod;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd7;
    logic [7:0] wr_data = 8'h00;
    logic       flag_ack = 1'b0;
    logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, ctrl_o;
    logic       upd_pulse, upd_flag, upd_irq;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    rtc_tod i_rtc_tod (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .flag_ack(flag_ack), .sec_o(sec_o), .min_o(min_o),
        .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
        .ctrl_o(ctrl_o), .upd_pulse(upd_pulse), .upd_flag(upd_flag), .upd_irq(upd_irq)
    );

    // ---------------- behavioural reference model ----------------
    int mb[6];
    int m_set, m_uie, m_bin, m_h24, m_dst, m_fell, m_pulse, m_uf;

    function automatic int dec(int v, int bin);
        return bin ? (v & 127) : ((v >> 4) & 15) * 10 + (v & 15);
    endfunction

    function automatic int enc(int n, int bin);
        return bin ? n : ((n / 10) << 4) | (n % 10);
    endfunction

    function automatic int mlen(int m);
        if (m == 2) return 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic model_step();
        int s, mi, h, v, t, dw, dt, mo, hh;
        s  = dec(mb[0], m_bin);
        mi = dec(mb[1], m_bin);
        if (m_h24) h = dec(mb[2], m_bin);
        else begin
            v = dec(mb[2] & 127, m_bin);
            h = (v % 12) + (((mb[2] >> 7) & 1) ? 12 : 0);
        end
        dw = dec(mb[3], m_bin);
        dt = dec(mb[4], m_bin);
        mo = dec(mb[5], m_bin);
        t = h * 3600 + mi * 60 + s;
        if (m_dst && t == 7199 && dw == 1 && mo == 4 && dt <= 7) t = 10800;
        else if (m_dst && t == 7199 && dw == 1 && mo == 10 && dt >= 25 && !m_fell) begin
            t = 3600; m_fell = 1;
        end else t = t + 1;
        if (t == 86400) begin
            t = 0;
            dw = (dw % 7) + 1;
            if (dt >= mlen(mo)) begin dt = 1; mo = (mo % 12) + 1; end
            else dt = dt + 1;
            m_fell = 0;
        end
        h = t / 3600; mi = (t / 60) % 60; s = t % 60;
        mb[0] = enc(s, m_bin);
        mb[1] = enc(mi, m_bin);
        if (m_h24) mb[2] = enc(h, m_bin);
        else begin
            hh = h % 12;
            if (hh == 0) hh = 12;
            mb[2] = enc(hh, m_bin) | ((h >= 12) ? 128 : 0);
        end
        mb[3] = enc(dw, m_bin);
        mb[4] = enc(dt, m_bin);
        mb[5] = enc(mo, m_bin);
    endtask

    always @(posedge clk) begin
        if (rst) begin
            mb[0] = 0; mb[1] = 0; mb[2] = 0; mb[3] = 1; mb[4] = 1; mb[5] = 1;
            m_set = 0; m_uie = 0; m_bin = 0; m_h24 = 1; m_dst = 0;
            m_fell = 0; m_pulse = 0; m_uf = 0;
        end else begin
            if (m_pulse) m_uf = 1;
            else if (flag_ack) m_uf = 0;
            m_pulse = 0;
            if (wr_en) begin
                if (wr_addr < 6) mb[wr_addr] = int'(wr_data);
                if (wr_addr == 4) m_fell = 0;
                if (wr_addr == 6) begin
                    m_dst = wr_data[0]; m_h24 = wr_data[1]; m_bin = wr_data[2];
                    m_uie = wr_data[4] ? 0 : int'(wr_data[3]);
                    m_set = wr_data[4];
                end
            end else if (tick && !m_set) begin
                model_step();
                m_pulse = 1;
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h at cycle %0d", cur_req, what, act, exp, cycles);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            cmp("sec", sec_o, mb[0]);
            cmp("min", min_o, mb[1]);
            cmp("hour", hour_o, mb[2]);
            cmp("dow", dow_o, mb[3]);
            cmp("date", date_o, mb[4]);
            cmp("month", month_o, mb[5]);
            cmp("ctrl", ctrl_o, (m_set << 4) | (m_uie << 3) | (m_bin << 2) | (m_h24 << 1) | m_dst);
            cmp("pulse", upd_pulse, m_pulse);
            cmp("flag", upd_flag, m_uf);
            cmp("irq", upd_irq, m_uf & m_uie);
        end
    end

    // ---------------- directed checks independent of the model ----------------
    task automatic chk(string tag, string what, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0; wr_addr = 3'd7;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    task automatic load(input logic [7:0] h, m, s, dw, dt, mo);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
        wr(3'd3, dw); wr(3'd4, dt); wr(3'd5, mo);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL %s watchdog: actual cycles=%0d expected below 100000", cur_req, cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        cur_req = "R1";
        chk("R1", "sec", sec_o, 8'h00);
        chk("R1", "hour", hour_o, 8'h00);
        chk("R1", "dow", dow_o, 8'h01);
        chk("R1", "month", month_o, 8'h01);
        chk("R1", "ctrl", ctrl_o, 8'h02);
        chk("R1", "flag", {7'b0, upd_flag}, 8'h00);

        // R2 and R7: midnight and year wrap in packed decimal
        cur_req = "R2";
        wr(3'd6, 8'h0A);
        load(8'h23, 8'h59, 8'h58, 8'h07, 8'h31, 8'h12);
        tk(1);
        chk("R2", "sec", sec_o, 8'h59);
        tick = 1'b1; @(posedge clk); #1; tick = 1'b0;
        chk("R2", "pulse", {7'b0, upd_pulse}, 8'h01);
        chk("R2", "hour wrap", hour_o, 8'h00);
        chk("R7", "date wrap", date_o, 8'h01);
        chk("R7", "month wrap", month_o, 8'h01);
        chk("R7", "dow wrap", dow_o, 8'h01);
        @(posedge clk); #1;
        chk("R2", "irq", {7'b0, upd_irq}, 8'h01);
        flag_ack = 1'b1; @(posedge clk); #1; flag_ack = 1'b0;
        chk("R2", "flag ack", {7'b0, upd_flag}, 8'h00);

        cur_req = "R7";
        load(8'h23, 8'h59, 8'h59, 8'h02, 8'h28, 8'h02);
        tk(1);
        chk("R7", "feb end date", date_o, 8'h01);
        chk("R7", "feb end month", month_o, 8'h03);
        load(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h04);
        tk(1);
        chk("R7", "apr end month", month_o, 8'h05);
        load(8'h23, 8'h59, 8'h59, 8'h03, 8'h30, 8'h05);
        tk(1);
        chk("R7", "may 31st", date_o, 8'h31);

        // R3, R4 freeze
        cur_req = "R4";
        wr(3'd6, 8'h1A);
        chk("R4", "uie forced low", ctrl_o, 8'h12);
        cur_req = "R3";
        tk(3);
        chk("R3", "frozen sec", sec_o, 8'h00);
        wr(3'd0, 8'h42);
        chk("R3", "write under freeze", sec_o, 8'h42);
        wr(3'd6, 8'h02);
        tk(1);
        chk("R3", "resume", sec_o, 8'h43);

        // R11 write beats tick
        cur_req = "R11";
        tick = 1'b1; wr(3'd0, 8'h10); tick = 1'b0;
        chk("R11", "write kept", sec_o, 8'h10);
        chk("R11", "no pulse", {7'b0, upd_pulse}, 8'h00);

        // R5 binary storage
        cur_req = "R5";
        wr(3'd6, 8'h06);
        load(8'd23, 8'd59, 8'd58, 8'd3, 8'd30, 8'd6);
        tk(1);
        chk("R5", "bin sec 59", sec_o, 8'd59);
        tk(1);
        chk("R5", "bin date", date_o, 8'd1);
        chk("R5", "bin month", month_o, 8'd7);
        chk("R5", "bin dow", dow_o, 8'd4);
        load(8'd9, 8'd9, 8'd9, 8'd4, 8'd1, 8'd7);
        tk(1);
        chk("R5", "bin 10s", sec_o, 8'd10);

        // R12 format change leaves bytes
        cur_req = "R12";
        wr(3'd6, 8'h02);
        chk("R12", "sec unchanged", sec_o, 8'd10);
        chk("R12", "month unchanged", month_o, 8'd7);

        // R6 12-hour mode
        cur_req = "R6";
        wr(3'd6, 8'h00);
        load(8'h11, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03);
        tk(1);
        chk("R6", "noon", hour_o, 8'h92);
        load(8'h92, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03);
        tk(1);
        chk("R6", "1 PM", hour_o, 8'h81);
        load(8'h91, 8'h59, 8'h59, 8'h02, 8'h10, 8'h03);
        tk(1);
        chk("R6", "midnight", hour_o, 8'h12);
        chk("R6", "day advance", date_o, 8'h11);
        wr(3'd6, 8'h04);
        load(8'd11, 8'd59, 8'd59, 8'd2, 8'd10, 8'd3);
        tk(1);
        chk("R6", "bin noon", hour_o, 8'h8C);

        // R8 spring forward
        cur_req = "R8";
        wr(3'd6, 8'h03);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h05, 8'h04);
        tk(1);
        chk("R8", "spring 24h", hour_o, 8'h03);
        wr(3'd6, 8'h01);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h07, 8'h04);
        tk(1);
        chk("R8", "spring 12h", hour_o, 8'h03);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h08, 8'h04);
        tk(1);
        chk("R8", "second week no jump", hour_o, 8'h02);

        // R9 fall back once
        cur_req = "R9";
        wr(3'd6, 8'h03);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h28, 8'h10);
        tk(1);
        chk("R9", "fall back", hour_o, 8'h01);
        chk("R9", "fall min", min_o, 8'h00);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tk(1);
        chk("R9", "no repeat", hour_o, 8'h02);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tk(1);
        chk("R9", "day advance", date_o, 8'h29);
        wr(3'd3, 8'h01); wr(3'd2, 8'h01); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tk(1);
        chk("R9", "guard cleared by day", hour_o, 8'h01);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h24, 8'h10);
        tk(1);
        chk("R9", "date 24 no jump", hour_o, 8'h02);

        // R10 daylight saving off
        cur_req = "R10";
        wr(3'd6, 8'h02);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h30, 8'h10);
        tk(1);
        chk("R10", "october plain", hour_o, 8'h02);
        load(8'h01, 8'h59, 8'h59, 8'h01, 8'h02, 8'h04);
        tk(1);
        chk("R10", "april plain", hour_o, 8'h02);

        repeat (4) @(posedge clk);
        #1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule